// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver with Error Flags

This block receives asynchronous serial characters on a single input line. It shares a 16x oversampling tick with the transmit side. The frame format is chosen at run time: 7, 8 or 9 data bits, sent least significant bit first; no parity, even parity or odd parity; and one or two stop bits. A falling edge on the idle-high line is confirmed at mid-bit as a start bit. Each later bit is sampled once at its centre and shifted into a holding register. When the frame ends, the finished character moves into a receive buffer, which the host reads through a one-cycle read strobe.

Each character brings its own framing and parity status. An overrun is flagged when a new character finishes while the buffer still holds an unread one. A sticky error summary flag is set whenever any error is present. An interrupt pulse is raised on every buffer load. A read, or dropping the receive enable, clears all error flags.

Top module: `uart_rx_core`

## Requirements
- R1: While `rx_en` is 0 the receiver stays idle, so a complete frame on `rxd` produces no `irq` and no buffer load.
- R2: A low level on the synchronised line at a tick starts a frame. The line is sampled again 8 ticks later. If it is high at that point, the event is dropped as a glitch and no character results.
- R3: Data bits arrive least significant bit first. `cfg_len` selects the length: 2'b00 gives 7 bits, 2'b01 gives 8 bits, and 2'b1x gives 9 bits. `rd_data` is zero-extended above the character.
- R4: Each buffer load raises `irq` for exactly one clock cycle, and `rd_data` shows the new character in that same cycle.
- R5: `cfg_par` sets the parity mode: 2'b0x means no parity bit, 2'b10 means even and 2'b11 means odd. `err_par` is set when the number of ones across the data and parity bits does not match the selected mode.
- R6: `err_frm` is set when a stop bit samples low. When `cfg_stop2` is 1, both stop bits are checked.
- R7: If a character finishes while the buffer is unread, `err_ovr` is set, the buffer keeps the earlier character, and `irq` is not raised.
- R8: `err_sum` is 1 whenever `err_ovr`, `err_frm` or `err_par` is 1, and it stays set until the flags are cleared.
- R9: A `rd_stb` pulse frees the buffer and clears all four error flags. If a read falls in the same cycle as a load, the load wins: the new character and its flags are kept, and no overrun is flagged.
- R10: When `rx_en` is 0, all error flags are cleared in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick16 | input | 1 | Oversampling enable, 16 per bit period |
| rxd | input | 1 | Serial input, idle high |
| rx_en | input | 1 | Receive enable |
| cfg_len | input | 2 | Character length select |
| cfg_par | input | 2 | Parity mode select |
| cfg_stop2 | input | 1 | 1 selects two stop bits |
| rd_stb | input | 1 | Buffer read strobe, one cycle |
| rd_data | output | 9 | Receive buffer contents |
| err_ovr | output | 1 | Overrun flag |
| err_frm | output | 1 | Framing error flag |
| err_par | output | 1 | Parity error flag |
| err_sum | output | 1 | Sticky error summary |
| irq | output | 1 | Buffer-load interrupt pulse |

## Verification
A host read and the load of a newly finished character can fall in the same clock cycle. The bench provokes this with a full buffer and a second frame that carries a parity error. It holds `rd_stb` high from the start of that frame's stop bit until `irq` is seen, then releases it. The result is judged correct when `irq` fires, `rd_data` holds the new character, `err_par` is still set from the new frame, and `err_ovr` stays clear. Any of these failing shows that the read either overrode the load or was taken as an overrun.

// File: rtl/uart_rx_pkg.sv
// Package: shared types for the oversampled serial receiver.
// Assumes the oversampling ratio is a power of two.
package uart_rx_pkg;

    typedef enum logic [2:0] {
        RX_IDLE  = 3'd0,
        RX_START = 3'd1,
        RX_DATA  = 3'd2,
        RX_PAR   = 3'd3,
        RX_STOP1 = 3'd4,
        RX_STOP2 = 3'd5
    } rx_state_t;

    // One finished frame as handed from the framer to the buffer.
    typedef struct packed {
        logic [8:0] data;
        logic       frm_bad;
        logic       par_bad;
    } rx_frame_t;

endpackage

// File: rtl/rx_sync.sv
// Module: rx_sync
// Brings the asynchronous serial line into the clock domain through a
// chain of flops. The chain resets high, matching the idle line level.
module rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            // Single-stage capture of the line.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= din;
            end
        end else begin : g_multi
            // Shift the line through the synchroniser chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= {chain_q[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/rx_framer.sv
// Module: rx_framer
// Finds the start bit, samples each bit at its centre and builds the
// character. At the end of the frame it issues a one-cycle done pulse
// with the character, the framing status and the parity status.
// Assumes rxd_s is already synchronised and tick is a one-cycle strobe.
module rx_framer
    import uart_rx_pkg::*;
#(
    parameter int DATA_W = 9,
    parameter int OSR    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              tick,
    input  logic              rxd_s,
    input  logic [1:0]        cfg_len,
    input  logic [1:0]        cfg_par,
    input  logic              cfg_stop2,
    output logic              done,
    output rx_frame_t         frame
);

    localparam int PH_W  = $clog2(OSR);
    localparam int IDX_W = $clog2(DATA_W);
    localparam logic [PH_W-1:0] MID = PH_W'(OSR / 2 - 1);

    rx_state_t         state_q;
    logic [PH_W-1:0]   ph_q;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] sr_q;
    logic              pbit_q;
    logic              frm_q;
    logic [IDX_W-1:0]  last_idx;
    logic              mid_hit;
    logic              ones_odd;

    // Index of the final data bit for the selected length.
    always_comb begin
        if (cfg_len[1])      last_idx = IDX_W'(DATA_W - 1);
        else if (cfg_len[0]) last_idx = IDX_W'(DATA_W - 2);
        else                 last_idx = IDX_W'(DATA_W - 3);
    end

    assign mid_hit  = tick && (ph_q == MID);
    assign ones_odd = (^sr_q) ^ pbit_q;

    // Frame state machine, phase counter and bit capture.
    always_ff @(posedge clk) begin
        if (!rst_n || !rx_en) begin
            state_q <= RX_IDLE;
            ph_q    <= '0;
            idx_q   <= '0;
            sr_q    <= '0;
            pbit_q  <= 1'b0;
            frm_q   <= 1'b0;
            done    <= 1'b0;
            frame   <= '0;
        end else begin
            done <= 1'b0;
            if (tick) ph_q <= ph_q + 1'b1;
            unique case (state_q)
                RX_IDLE: begin
                    ph_q <= '0;
                    if (tick && !rxd_s) begin
                        state_q <= RX_START;
                        sr_q    <= '0;
                        pbit_q  <= 1'b0;
                        frm_q   <= 1'b0;
                        idx_q   <= '0;
                    end
                end
                RX_START: if (mid_hit) begin
                    state_q <= rxd_s ? RX_IDLE : RX_DATA;
                end
                RX_DATA: if (mid_hit) begin
                    sr_q[idx_q] <= rxd_s;
                    idx_q       <= idx_q + 1'b1;
                    if (idx_q == last_idx)
                        state_q <= cfg_par[1] ? RX_PAR : RX_STOP1;
                end
                RX_PAR: if (mid_hit) begin
                    pbit_q  <= rxd_s;
                    state_q <= RX_STOP1;
                end
                RX_STOP1: if (mid_hit) begin
                    if (cfg_stop2) begin
                        frm_q   <= !rxd_s;
                        state_q <= RX_STOP2;
                    end else begin
                        done          <= 1'b1;
                        frame.data    <= 9'(sr_q);
                        frame.frm_bad <= !rxd_s;
                        frame.par_bad <= cfg_par[1] && (cfg_par[0] ? !ones_odd : ones_odd);
                        state_q       <= RX_IDLE;
                    end
                end
                RX_STOP2: if (mid_hit) begin
                    done          <= 1'b1;
                    frame.data    <= 9'(sr_q);
                    frame.frm_bad <= frm_q || !rxd_s;
                    frame.par_bad <= cfg_par[1] && (cfg_par[0] ? !ones_odd : ones_odd);
                    state_q       <= RX_IDLE;
                end
                default: state_q <= RX_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/rx_buffer.sv
// Module: rx_buffer
// Receive buffer with error flags and load interrupt. A read in the same
// cycle as a load frees the old entry first, so the load goes through.
// Assumes done is a one-cycle pulse from the framer.
module rx_buffer
    import uart_rx_pkg::*;
#(
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              done,
    input  rx_frame_t         frame,
    input  logic              rd_stb,
    output logic [DATA_W-1:0] rd_data,
    output logic              err_ovr,
    output logic              err_frm,
    output logic              err_par,
    output logic              err_sum,
    output logic              irq
);

    logic full_q;
    logic busy;

    assign busy = full_q && !rd_stb;

    // Buffer occupancy, flags and interrupt pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
            full_q  <= 1'b0;
            err_ovr <= 1'b0;
            err_frm <= 1'b0;
            err_par <= 1'b0;
            err_sum <= 1'b0;
            irq     <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (rd_stb) full_q <= 1'b0;
            if (rd_stb || !rx_en) begin
                err_ovr <= 1'b0;
                err_frm <= 1'b0;
                err_par <= 1'b0;
                err_sum <= 1'b0;
            end
            if (rx_en && done) begin
                if (busy) begin
                    err_ovr <= 1'b1;
                    err_sum <= 1'b1;
                end else begin
                    rd_data <= DATA_W'(frame.data);
                    full_q  <= 1'b1;
                    err_frm <= frame.frm_bad;
                    err_par <= frame.par_bad;
                    err_sum <= frame.frm_bad || frame.par_bad;
                    irq     <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/uart_rx_core.sv
// Module: uart_rx_core
// Top of the serial receiver: synchroniser, framer and receive buffer.
// Assumes tick16 pulses OSR times per bit period.
module uart_rx_core
    import uart_rx_pkg::*;
#(
    parameter int DATA_W      = 9,
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16,
    input  logic              rxd,
    input  logic              rx_en,
    input  logic [1:0]        cfg_len,
    input  logic [1:0]        cfg_par,
    input  logic              cfg_stop2,
    input  logic              rd_stb,
    output logic [DATA_W-1:0] rd_data,
    output logic              err_ovr,
    output logic              err_frm,
    output logic              err_par,
    output logic              err_sum,
    output logic              irq
);

    logic      rxd_s;
    logic      fr_done;
    rx_frame_t fr_data;

    rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst_n(rst_n),
        .din (rxd),
        .dout(rxd_s)
    );

    rx_framer #(.DATA_W(DATA_W), .OSR(OSR)) u_framer (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_en    (rx_en),
        .tick     (tick16),
        .rxd_s    (rxd_s),
        .cfg_len  (cfg_len),
        .cfg_par  (cfg_par),
        .cfg_stop2(cfg_stop2),
        .done     (fr_done),
        .frame    (fr_data)
    );

    rx_buffer #(.DATA_W(DATA_W)) u_buf (
        .clk    (clk),
        .rst_n  (rst_n),
        .rx_en  (rx_en),
        .done   (fr_done),
        .frame  (fr_data),
        .rd_stb (rd_stb),
        .rd_data(rd_data),
        .err_ovr(err_ovr),
        .err_frm(err_frm),
        .err_par(err_par),
        .err_sum(err_sum),
        .irq    (irq)
    );

endmodule

// File: rtl/uart_rx_core_chk.sv
// Module: uart_rx_core_chk
// Property checker attached to every uart_rx_core instance.
module uart_rx_core_chk #(
    parameter int DATA_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_en,
    input logic              rd_stb,
    input logic [DATA_W-1:0] rd_data,
    input logic              err_ovr,
    input logic              err_frm,
    input logic              err_par,
    input logic              err_sum,
    input logic              irq
);

    // R4: the interrupt lasts one cycle
    a_r4_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R7: a load never coincides with an active overrun
    a_r7_no_irq_on_ovr: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !err_ovr);

    // R7: the buffer holds its contents when an overrun is raised
    a_r7_keep_data: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_ovr) |-> $stable(rd_data));

    // R8: summary covers every error flag
    a_r8_sum_covers: assert property (@(posedge clk) disable iff (!rst_n)
        (err_ovr || err_frm || err_par) |-> err_sum);

    // R9: a read leaves no overrun behind
    a_r9_read_clears_ovr: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> !err_ovr);

    // R10: disabling clears flags and suppresses loads
    a_r10_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> (!err_sum && !irq));

endmodule

bind uart_rx_core uart_rx_core_chk #(.DATA_W(DATA_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .rx_en  (rx_en),
    .rd_stb (rd_stb),
    .rd_data(rd_data),
    .err_ovr(err_ovr),
    .err_frm(err_frm),
    .err_par(err_par),
    .err_sum(err_sum),
    .irq    (irq)
);

// File: tb/uart_rx_core_tb_top.sv
// Scoreboard bench: the frame driver queues the expected character and
// flags, and the monitor compares them whenever irq is raised.
`timescale 1ns/1ps
module uart_rx_core_tb_top;

    typedef struct packed {
        logic [8:0] d;
        logic       f;
        logic       p;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       rxd = 1'b1;
    logic       rx_en = 1'b0;
    logic [1:0] cfg_len = 2'b01;
    logic [1:0] cfg_par = 2'b00;
    logic       cfg_stop2 = 1'b0;
    logic       rd_stb = 1'b0;
    logic [8:0] rd_data;
    logic       err_ovr, err_frm, err_par, err_sum, irq;

    exp_t exp_q[$];
    int   n_run = 0;
    int   n_fail = 0;
    int   irq_cnt = 0;
    bit   done_flag = 0;

    uart_rx_core dut_i (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd), .rx_en(rx_en),
        .cfg_len(cfg_len), .cfg_par(cfg_par), .cfg_stop2(cfg_stop2),
        .rd_stb(rd_stb), .rd_data(rd_data), .err_ovr(err_ovr),
        .err_frm(err_frm), .err_par(err_par), .err_sum(err_sum), .irq(irq)
    );

    always #4 clk = ~clk;

    // Oversampling tick: high every other cycle, changed away from the edge.
    initial begin
        forever begin
            @(negedge clk);
            tick16 = !tick16;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // One bit period is 16 ticks, which is 32 clocks.
    task automatic drive_bit(input logic b);
        rxd = b;
        repeat (32) @(negedge clk);
    endtask

    task automatic send_frame(input logic [8:0] d, input int nb, input logic [1:0] par,
                              input bit st2, input bit flip, input bit bad1,
                              input bit bad2, input bit push);
        logic [8:0] m;
        logic       pb;
        exp_t       e;
        m = d & ((9'h1 << nb) - 9'h1);
        pb = (^m) ^ par[0] ^ flip;
        if (push) begin
            e.d = m;
            e.f = bad1 || (st2 && bad2);
            e.p = par[1] && flip;
            exp_q.push_back(e);
        end
        drive_bit(1'b0);
        for (int i = 0; i < nb; i++) drive_bit(m[i]);
        if (par[1]) drive_bit(pb);
        drive_bit(!bad1);
        if (st2) drive_bit(!bad2);
        drive_bit(1'b1);
        drive_bit(1'b1);
    endtask

    task automatic do_read();
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        @(negedge clk);
        chk({err_ovr, err_frm, err_par, err_sum} == 4'b0, "R9 flags cleared by read",
            {err_ovr, err_frm, err_par, err_sum}, 0);
    endtask

    // Monitor: compare each buffer load against the scoreboard.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && irq) begin
                exp_t e;
                irq_cnt++;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R4 unexpected irq", 1, 0);
                end else begin
                    e = exp_q.pop_front();
                    chk(rd_data == e.d, "R3 data", rd_data, e.d);
                    chk(err_frm == e.f, "R6 framing flag", err_frm, e.f);
                    chk(err_par == e.p, "R5 parity flag", err_par, e.p);
                    chk(err_sum == (e.f | e.p), "R8 summary flag", err_sum, e.f | e.p);
                    chk(!err_ovr, "R7 no overrun on load", err_ovr, 0);
                end
            end
        end
    end

    initial begin
        #(8 * 150000);
        if (!done_flag) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int base;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state.
        chk(rd_data == 9'h0, "R4 reset data", rd_data, 0);
        chk(!irq, "R4 reset irq", irq, 0);
        chk({err_ovr, err_frm, err_par, err_sum} == 4'b0, "R8 reset flags",
            {err_ovr, err_frm, err_par, err_sum}, 0);

        // R1: a disabled receiver ignores a complete frame.
        base = irq_cnt;
        send_frame(9'h0A5, 8, 2'b00, 0, 0, 0, 0, 0);
        chk(irq_cnt == base, "R1 disabled ignores frame", irq_cnt - base, 0);
        chk(rd_data == 9'h0, "R1 buffer untouched", rd_data, 0);
        rx_en = 1'b1;
        repeat (8) @(negedge clk);

        // R3: 8 bits, no parity, 1 stop.
        base = irq_cnt;
        send_frame(9'h0A5, 8, 2'b00, 0, 0, 0, 0, 1);
        chk(irq_cnt == base + 1, "R4 one irq per load", irq_cnt - base, 1);
        do_read();

        // R3/R5: 7 bits, even parity.
        cfg_len = 2'b00; cfg_par = 2'b10;
        send_frame(9'h0D3, 7, 2'b10, 0, 0, 0, 0, 1);
        do_read();

        // R3/R5/R6: 9 bits, odd parity, 2 stop bits.
        cfg_len = 2'b10; cfg_par = 2'b11; cfg_stop2 = 1'b1;
        send_frame(9'h1C6, 9, 2'b11, 1, 0, 0, 0, 1);
        do_read();

        // R5: even parity with a corrupted parity bit.
        cfg_len = 2'b01; cfg_par = 2'b10; cfg_stop2 = 1'b0;
        send_frame(9'h03C, 8, 2'b10, 0, 1, 0, 0, 1);
        do_read();

        // R6: single stop bit sampled low.
        cfg_par = 2'b00;
        send_frame(9'h055, 8, 2'b00, 0, 0, 1, 0, 1);
        do_read();

        // R6: two stop bits, second one low.
        cfg_stop2 = 1'b1;
        send_frame(9'h0F0, 8, 2'b00, 1, 0, 0, 1, 1);
        do_read();
        cfg_stop2 = 1'b0;

        // R2: a short low pulse is rejected at mid-bit.
        base = irq_cnt;
        rxd = 1'b0;
        repeat (6) @(negedge clk);
        rxd = 1'b1;
        repeat (96) @(negedge clk);
        chk(irq_cnt == base, "R2 glitch rejected", irq_cnt - base, 0);
        chk(rd_data == 9'h0F0, "R2 buffer unchanged by glitch", rd_data, 9'h0F0);

        // R7: overrun keeps the first character.
        base = irq_cnt;
        send_frame(9'h011, 8, 2'b00, 0, 0, 0, 0, 1);
        send_frame(9'h022, 8, 2'b00, 0, 0, 0, 0, 0);
        chk(irq_cnt == base + 1, "R7 no irq on overrun", irq_cnt - base, 1);
        chk(err_ovr, "R7 overrun flag", err_ovr, 1);
        chk(err_sum, "R8 summary on overrun", err_sum, 1);
        chk(rd_data == 9'h011, "R7 earlier data kept", rd_data, 9'h011);
        do_read();

        // R10: dropping enable clears pending flags.
        send_frame(9'h033, 8, 2'b00, 0, 0, 1, 0, 1);
        rx_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk({err_ovr, err_frm, err_par, err_sum} == 4'b0, "R10 disable clears flags",
            {err_ovr, err_frm, err_par, err_sum}, 0);
        rx_en = 1'b1;
        do_read();

        // R9: read held across the load of a new character with a parity error.
        cfg_par = 2'b11;
        send_frame(9'h044, 8, 2'b11, 0, 0, 0, 0, 1);
        base = irq_cnt;
        fork
            send_frame(9'h099, 8, 2'b11, 0, 1, 0, 0, 1);
            begin
                repeat (10 * 32) @(negedge clk);
                rd_stb = 1'b1;
                while (irq_cnt == base) @(negedge clk);
                rd_stb = 1'b0;
            end
        join
        chk(irq_cnt == base + 1, "R9 load wins over read", irq_cnt - base, 1);
        chk(!err_ovr, "R9 no overrun on read-load", err_ovr, 0);
        chk(err_par, "R9 new parity flag kept", err_par, 1);
        chk(rd_data == 9'h099, "R9 new data kept", rd_data, 9'h099);
        do_read();

        chk(exp_q.size() == 0, "R4 all expected loads seen", exp_q.size(), 0);
        done_flag = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule